// File: doc/BRIEF.md
# Stochastic-Residue SAR Conversion Sequencer

This block sequences one successive-approximation conversion of CODE_W bits (12 by default) and then measures the remaining residue statistically. While the sample strobe is high the converter tracks its input and the DAC control word is held at zero. When the strobe is seen low, the sequencer places the MSB trial on the DAC. It waits a programmable number of settling cycles, then makes one decision per clock from MSB down to LSB. A comparator result of 1 keeps the trial bit and a result of 0 clears it.

Once the search ends, the final code stays on the DAC. The sequencer then takes a run of further comparator samples against that code. The comparator noise makes these samples differ, and the number of ones among them is a fine estimate of the residue. The length of the run comes from a repeat-count input, captured when conversion starts. Useful settings are 7 to 255, and 0 skips the phase. When the run ends, the coarse code and the ones-count are registered in the same clock edge and a one-cycle done pulse is given. The sequencer then idles until the next sample strobe. A new strobe that arrives during a conversion abandons that conversion.

A system clock stands in for the self-timed comparison clock. The analog DAC and the comparator sit outside the block.

Top module: `sar_seq_top`

## Requirements
- R1: While reset is asserted, dacWord, sarCode and onesCount are zero and doneOut is low.
- R2: On every clock edge at which sampleIn is high, dacWord is cleared to zero and no conversion is in progress. A conversion starts at the first edge at which sampleIn is seen low after being high.
- R3: At the start edge the MSB trial (only bit CODE_W-1 set, 12'h800 by default) appears on dacWord. It stays there unchanged for MSB_SETTLE further edges (default 2) before the first decision.
- R4: The search makes exactly CODE_W decisions, one per edge, from bit CODE_W-1 down to bit 0. At the decision for bit i, a cmpIn of 1 keeps bit i, a cmpIn of 0 clears it, and bit i-1 is set as the next trial. If the comparator returns 1 exactly when dacWord <= input, the final code equals the input.
- R5: After the search, exactly N repeat comparisons are taken, one per edge. N is the repCount value captured at the start edge. dacWord stays at the final SAR code throughout.
- R6: onesCount reports how many of the N repeat comparisons saw cmpIn = 1. Its value lies between 0 and N.
- R7: With a captured repeat count of 0, no repeat cycle runs and onesCount reports 0. With MSB_SETTLE = 2, doneOut then rises one edge after the last search decision.
- R8: doneOut is a one-cycle pulse. With MSB_SETTLE = 2 it is high during the cycle after edge 15+N, where edge 0 is the start edge. sarCode and onesCount change only at the edge that raises doneOut.
- R9: If sampleIn goes high at any edge before doneOut is raised, the conversion is abandoned. No done pulse is given for it, and sarCode and onesCount keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 1 | Sample strobe, high = track input |
| cmpIn | input | 1 | Comparator decision, 1 = DAC level not above input |
| repCount | input | REP_W (8) | Number of residue comparisons, captured at conversion start |
| dacWord | output | CODE_W (12) | DAC control word |
| sarCode | output | CODE_W (12) | Registered coarse SAR result |
| onesCount | output | REP_W (8) | Registered count of ones in the repeat phase |
| doneOut | output | 1 | One-cycle pulse when both results update |

## Verification
An abort and the result publication can fall in the same cycle. This happens when the sample strobe rises exactly at the edge where the finished conversion would publish its codes. The bench provokes this by counting edges from the start edge to the publish edge of a conversion with a known repeat length, and raising the strobe just before that edge. It judges the outcome from the ports: doneOut must stay low, sarCode and onesCount must keep the previous conversion's values, and dacWord must return to zero. A second abort in the middle of the binary search checks the same retention rule away from that boundary.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_SETTLE,
    ST_SEARCH,
    ST_REPEAT,
    ST_FINISH
  } seqState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic clrDac;   // strobe high: zero the DAC word
    logic loadMsb;  // start of conversion: MSB trial
    logic decide;   // resolve one SAR bit
    logic clrOnes;  // clear the residue counter
    logic addCmp;   // repeat phase: accumulate comparator
    logic publish;  // register both results and pulse done
  } seqStrobe_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int REP_W      = 8,
  parameter int MSB_SETTLE = 2,
  localparam int IDX_W     = $clog2(CODE_W),
  localparam int SET_W     = $clog2(MSB_SETTLE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleIn,
  input  logic [REP_W-1:0] repCount,
  output seqStrobe_t       strb,
  output logic [IDX_W-1:0] bitIdx
);

  seqState_t        state;
  logic [SET_W-1:0] settleCnt;
  logic [REP_W-1:0] repLatch;
  logic [REP_W-1:0] repCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      repLatch  <= '0;
      repCnt    <= '0;
      bitIdx    <= '0;
    end else if (sampleIn) begin
      state <= ST_SAMPLE;
    end else begin
      unique case (state)
        ST_SAMPLE: begin
          state     <= ST_SETTLE;
          settleCnt <= '0;
          repLatch  <= repCount;
          bitIdx    <= IDX_W'(CODE_W - 1);
        end
        ST_SETTLE: begin
          if (settleCnt == SET_W'(MSB_SETTLE - 1)) state <= ST_SEARCH;
          else settleCnt <= settleCnt + 1'b1;
        end
        ST_SEARCH: begin
          if (bitIdx == '0) begin
            repCnt <= '0;
            state  <= (repLatch == '0) ? ST_FINISH : ST_REPEAT;
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
        ST_REPEAT: begin
          if (repCnt == repLatch - 1'b1) state <= ST_FINISH;
          else repCnt <= repCnt + 1'b1;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.clrDac  = sampleIn;
    strb.loadMsb = !sampleIn && (state == ST_SAMPLE);
    strb.clrOnes = !sampleIn && (state == ST_SAMPLE);
    strb.decide  = !sampleIn && (state == ST_SEARCH);
    strb.addCmp  = !sampleIn && (state == ST_REPEAT);
    strb.publish = !sampleIn && (state == ST_FINISH);
  end

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int REP_W  = 8,
  localparam int IDX_W = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              cmpIn,
  output logic [CODE_W-1:0] dacWord,
  output logic [CODE_W-1:0] sarCode,
  output logic [REP_W-1:0]  onesCount,
  output logic              doneOut
);

  localparam logic [CODE_W-1:0] MSB_TRIAL = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] dacNext;
  logic [REP_W-1:0]  onesReg;

  // Resolve the current bit and raise the next trial bit
  always_comb begin
    dacNext         = dacWord;
    dacNext[bitIdx] = cmpIn;
    if (bitIdx != '0) dacNext[bitIdx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacWord <= '0;
    end else if (strb.clrDac) begin
      dacWord <= '0;
    end else if (strb.loadMsb) begin
      dacWord <= MSB_TRIAL;
    end else if (strb.decide) begin
      dacWord <= dacNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesReg <= '0;
    end else if (strb.clrOnes) begin
      onesReg <= '0;
    end else if (strb.addCmp) begin
      onesReg <= onesReg + REP_W'(cmpIn);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarCode   <= '0;
      onesCount <= '0;
      doneOut   <= 1'b0;
    end else begin
      doneOut <= strb.publish;
      if (strb.publish) begin
        sarCode   <= dacWord;
        onesCount <= onesReg;
      end
    end
  end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int REP_W      = 8,
  parameter int MSB_SETTLE = 2,
  localparam int IDX_W     = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleIn,
  input  logic              cmpIn,
  input  logic [REP_W-1:0]  repCount,
  output logic [CODE_W-1:0] dacWord,
  output logic [CODE_W-1:0] sarCode,
  output logic [REP_W-1:0]  onesCount,
  output logic              doneOut
);

  seqStrobe_t       ctlStrb;
  logic [IDX_W-1:0] bitIdx;
  logic             repPhase;

  assign repPhase = ctlStrb.addCmp;

  sar_seq_ctrl #(
    .CODE_W(CODE_W), .REP_W(REP_W), .MSB_SETTLE(MSB_SETTLE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .repCount(repCount),
    .strb(ctlStrb), .bitIdx(bitIdx)
  );

  sar_seq_dp #(
    .CODE_W(CODE_W), .REP_W(REP_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(ctlStrb), .bitIdx(bitIdx), .cmpIn(cmpIn),
    .dacWord(dacWord), .sarCode(sarCode), .onesCount(onesCount),
    .doneOut(doneOut)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int CODE_W = 12,
  parameter int REP_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleIn,
  input logic [CODE_W-1:0] dacWord,
  input logic [CODE_W-1:0] sarCode,
  input logic [REP_W-1:0]  onesCount,
  input logic              doneOut,
  input logic              repPhase
);

  // R1: reset values seen at the ports
  always_comb begin
    if (!rstN) begin
      a_reset_r1: assert (dacWord == '0 && sarCode == '0 && onesCount == '0 && !doneOut)
        else $error("reset values wrong");
    end
  end

  p_sample_dac_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleIn |=> (dacWord == '0));

  p_repeat_dac_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (repPhase && $past(repPhase)) |-> $stable(dacWord));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_results_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> ($stable(sarCode) && $stable(onesCount)));

  p_abort_no_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    sampleIn |=> !doneOut);

endmodule

bind sar_seq_top sar_seq_chk #(.CODE_W(CODE_W), .REP_W(REP_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .dacWord(dacWord),
  .sarCode(sarCode), .onesCount(onesCount), .doneOut(doneOut),
  .repPhase(repPhase)
);

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
  localparam int CW     = 12;
  localparam int RW     = 8;
  localparam int SETTLE = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleIn = 1'b0;
  logic          cmpIn = 1'b0;
  logic [RW-1:0] repCount = '0;
  logic [CW-1:0] dacWord, sarCode;
  logic [RW-1:0] onesCount;
  logic          doneOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  int lastCode = 0;
  int lastOnes = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  sar_seq_top i_sar_seq_top (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .cmpIn(cmpIn),
    .repCount(repCount), .dacWord(dacWord), .sarCode(sarCode),
    .onesCount(onesCount), .doneOut(doneOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic noiseBit(input int mode, output bit b);
    if (mode == 0) b = 1'b0;
    else if (mode == 1) b = 1'b1;
    else begin
      b = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
  endtask

  // One conversion. abortAt >= 0: raise the strobe before that search decision.
  // abortEnd: raise the strobe before the publish edge.
  task automatic runConv(input int vin, input int n, input int mode,
                         input int abortAt, input bit abortEnd, input string tag);
    int  expOnes = 0;
    bit  b;
    bit  held = 1'b1;
    bit  sawDone = 1'b0;
    repCount = n[RW-1:0];
    sampleIn = 1'b1;
    @(negedge clk); @(negedge clk);
    check(dacWord == 0 && !doneOut, {tag, " R2 DAC zero while sampling"}, int'(dacWord), 0);
    sampleIn = 1'b0;
    @(negedge clk);                       // after start edge
    check(dacWord == 12'h800, {tag, " R3 MSB trial at start"}, int'(dacWord), 2048);
    for (int s = 0; s < SETTLE; s++) @(negedge clk);
    check(dacWord == 12'h800, {tag, " R3 MSB trial held through settle"}, int'(dacWord), 2048);
    for (int i = 0; i < CW; i++) begin
      if (i == abortAt) begin
        sampleIn = 1'b1;
        @(negedge clk);
        check(dacWord == 0, {tag, " R2 DAC cleared on abort"}, int'(dacWord), 0);
        for (int w = 0; w < n + 20; w++) begin
          if (doneOut) sawDone = 1'b1;
          @(negedge clk);
        end
        check(!sawDone, {tag, " R9 no done after mid-search abort"}, int'(sawDone), 0);
        check(int'(sarCode) == lastCode && int'(onesCount) == lastOnes,
              {tag, " R9 results kept after abort"}, int'(sarCode), lastCode);
        return;
      end
      cmpIn = (int'(dacWord) <= vin);
      @(negedge clk);
    end
    check(int'(dacWord) == vin, {tag, " R4 final SAR code on DAC"}, int'(dacWord), vin);
    for (int i = 0; i < n; i++) begin
      noiseBit(mode, b);
      cmpIn = b;
      expOnes += int'(b);
      if (int'(dacWord) != vin || doneOut) held = 1'b0;
      @(negedge clk);
    end
    check(held, {tag, " R5 DAC held, no done during repeat"}, int'(dacWord), vin);
    cmpIn = 1'b0;
    check(!doneOut, {tag, " R8 no done before publish edge"}, int'(doneOut), 0);
    if (abortEnd) begin
      sampleIn = 1'b1;
      @(negedge clk);
      check(!doneOut, {tag, " R9 no done when strobe meets publish"}, int'(doneOut), 0);
      check(int'(sarCode) == lastCode && int'(onesCount) == lastOnes,
            {tag, " R9 results kept at publish abort"}, int'(sarCode), lastCode);
      check(dacWord == 0, {tag, " R2 DAC zero at publish abort"}, int'(dacWord), 0);
      return;
    end
    @(negedge clk);
    check(doneOut, {tag, " R8 done at publish edge"}, int'(doneOut), 1);
    check(int'(sarCode) == vin, {tag, " R4 sarCode"}, int'(sarCode), vin);
    check(int'(onesCount) == expOnes, {tag, " R6 onesCount"}, int'(onesCount), expOnes);
    @(negedge clk);
    check(!doneOut, {tag, " R8 done is one cycle"}, int'(doneOut), 0);
    check(int'(sarCode) == vin && int'(onesCount) == expOnes,
          {tag, " R8 results held after done"}, int'(sarCode), vin);
    lastCode = vin;
    lastOnes = expOnes;
  endtask

  task automatic tResetState();
    @(negedge clk);
    check(dacWord == 0 && sarCode == 0 && onesCount == 0 && !doneOut,
          "R1 reset state", int'(sarCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!doneOut && dacWord == 0, "R1 idle after reset", int'(dacWord), 0);
  endtask

  task automatic tNoisyMid();    runConv(1234, 31, 2, -1, 1'b0, "noisy31");    endtask
  task automatic tZeroInOnes();  runConv(0,     7, 1, -1, 1'b0, "zero-in");    endtask
  task automatic tFullScale();   runConv(4095, 255, 2, -1, 1'b0, "fullscale"); endtask
  task automatic tNoRepeat();    runConv(2048,  0, 1, -1, 1'b0, "R7 norep");   endtask
  task automatic tAllZeros();    runConv(1,    20, 0, -1, 1'b0, "zeros20");    endtask
  task automatic tAbortSearch(); runConv(3000, 12, 2,  5, 1'b0, "abort-mid");  endtask
  task automatic tAbortPublish();runConv(777,  10, 1, -1, 1'b1, "abort-end");  endtask
  task automatic tAfterAbort();  runConv(2730,  9, 2, -1, 1'b0, "recover");    endtask

  initial begin
    tResetState();
    tNoisyMid();
    tZeroInOnes();
    tFullScale();
    tNoRepeat();
    tAllZeros();
    tAbortSearch();
    tAbortPublish();
    tAfterAbort();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule